// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is a timer counter that advances on enable ticks instead of on every clock edge. One of several tick sources, all in the same clock domain, is picked by a select input. The picked ticks go through a power-of-two prescaler. The surviving ticks step a counter whose width can be set at run time to 8, 10, 12 or 16 bits.

Four counting patterns are available:
- **Stop** holds the count.
- **Up** counts from zero to a programmed period value.
- **Continuous** runs to the full-scale value of the selected width.
- **Up/down** climbs to the period and walks back down to zero.

If the period does not fit in the selected width, up and up/down modes behave as continuous.

Two single-cycle strobes report when the count steps onto its turning point (`evt_top`) and onto zero (`evt_zero`). A direction flag shows whether the counter is descending. Software-style preload of the count is possible through a load port. A load never raises a strobe, because only a tick-driven step into a value counts as reaching it. A synchronous clear returns the count, the prescaler and the direction to their start state.

Top module: `mm_timer`

## Requirements
- R1: After reset, and one cycle after `clr` is high, `cnt` is 0, `dir_down` is 0 and both strobes are 0. `clr` also empties the prescaler, so a new full division period is needed before the next step.
- R2: `mode` encoding: 0 = stop, 1 = up, 2 = continuous, 3 = up/down. In stop mode the count and the prescaler do not move, whatever the tick inputs do.
- R3: In up mode each advancing tick adds 1 until the count equals `period`; the next tick returns it to 0. `evt_top` is high in the cycle the count becomes `period`; `evt_zero` is high in the cycle it becomes 0.
- R4: In continuous mode the count runs to the full-scale value of the selected width, then wraps to 0. `evt_top` is high on reaching full scale and `evt_zero` on the wrap.
- R5: In up/down mode the count rises to `period`, then falls one per tick to 0, then rises again. `dir_down` becomes 1 in the cycle the count reaches `period` and returns to 0 in the cycle it reaches 0. The strobes fire at those two points.
- R6: `len_sel` encoding: 0 = 8 bits, 1 = 10 bits, 2 = 12 bits, 3 = 16 bits. Full scale is 2^bits − 1.
- R7: In up or up/down mode, a `period` above full scale of the selected width makes the counter behave exactly as in continuous mode, with `dir_down` staying 0.
- R8: `div_sel` encoding: 0 = ÷1, 1 = ÷2, 2 = ÷4, 3 = ÷8. The counter advances on every 1st, 2nd, 4th or 8th selected tick respectively.
- R9: Only `src_tick[src_sel]` feeds the prescaler; ticks on other sources have no effect on the count.
- R10: `ld` writes `ld_val` masked to the selected width into the count, without raising either strobe. `clr` has priority over `ld`, and a tick in a load cycle does not step the counter.
- R11: A strobe is high only in a cycle where a tick step moved the count onto the target value. It is low in the following cycle unless another step lands there.
- R12: After the width is reduced, the next advancing tick steps from the count masked to the new width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | Candidate enable ticks, one per source |
| src_sel | input | SELW | Index of the tick source in use |
| div_sel | input | 2 | Prescaler ratio code |
| mode | input | 2 | Counting pattern code |
| len_sel | input | 2 | Counter width code |
| period | input | 16 | Turning point for up and up/down modes |
| clr | input | 1 | Synchronous clear |
| ld | input | 1 | Load strobe for the count |
| ld_val | input | 16 | Value to load |
| cnt | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting down in up/down mode |
| evt_top | output | 1 | Count stepped onto its turning point |
| evt_zero | output | 1 | Count stepped onto zero |

## Verification
The bench targets the turning points:
- **Up/down reversal.** A design that reverses one step late overshoots the period. One that flips `dir_down` on the wrong cycle shows the wrong direction at the top or at zero.
- **Oversized period.** It is set in both up and up/down modes. A faulty fallback would wrap early or start descending from full scale.
- **Preload onto a target.** A design that compares the count rather than the step would raise a strobe on the load.
- **Width shrink.** It is performed with a count above the new full scale. A missing mask would let the counter climb past it.
- **Prescaler after `clr`.** It is checked partway through a division period, so a prescaler that was not cleared steps too early.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } mode_e;

  // number of active counter bits for a width code
  function automatic int len_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/mm_tick_src.sv
module mm_tick_src #(
  parameter int NSRC = 4,
  parameter int SELW = 2,
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] src_sel,
  input  logic [1:0]      div_sel,
  input  logic            run,
  input  logic            clr,
  output logic            adv
);

  logic [NSRC-1:0] hit;
  logic            sel_tick;
  logic [DIVW-1:0] div_q, div_d, div_lim;

  // one gate per source, enabled by the select index
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src_tick[i] & (src_sel == SELW'(i));
  end

  assign sel_tick = |hit;

  always_comb begin
    case (div_sel)
      2'd0:    div_lim = DIVW'(0);
      2'd1:    div_lim = DIVW'(1);
      2'd2:    div_lim = DIVW'(3);
      default: div_lim = DIVW'(7);
    endcase
  end

  assign adv = run & sel_tick & (div_q >= div_lim);

  always_comb begin
    div_d = div_q;
    if (clr)                  div_d = '0;
    else if (run && sel_tick) div_d = adv ? '0 : div_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/mm_limit.sv
module mm_limit
  import mm_timer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [1:0]    len_sel,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] maxv,
  output logic [CW-1:0] top,
  output mode_e         eff_mode
);

  logic oor;

  always_comb begin
    maxv = {CW{1'b1}} >> (CW - len_bits(len_sel));
    oor  = period > maxv;
    eff_mode = mode_e'(mode);
    if ((eff_mode == MODE_UP || eff_mode == MODE_UPDN) && oor) eff_mode = MODE_CONT;
    top = (eff_mode == MODE_CONT) ? maxv : period;
  end

endmodule

// File: rtl/mm_step.sv
module mm_step
  import mm_timer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [CW-1:0] cur,
  input  logic          dir,
  input  mode_e         eff_mode,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] nxt,
  output logic          dir_nxt
);

  logic [CW-1:0] inc, dec;

  assign inc = cur + CW'(1);
  assign dec = cur - CW'(1);

  always_comb begin
    nxt     = cur;
    dir_nxt = dir;
    case (eff_mode)
      MODE_UP, MODE_CONT: begin
        nxt     = (cur >= top) ? '0 : inc;
        dir_nxt = 1'b0;
      end
      MODE_UPDN: begin
        if (!dir) begin
          if (cur < top) begin
            nxt = inc; dir_nxt = (inc >= top);
          end else if (cur != '0) begin
            nxt = dec; dir_nxt = (dec != '0);
          end else begin
            nxt = '0; dir_nxt = 1'b0;
          end
        end else begin
          if (cur != '0) begin
            nxt = dec; dir_nxt = (dec != '0);
          end else if (top != '0) begin
            nxt = inc; dir_nxt = (inc >= top);
          end else begin
            nxt = '0; dir_nxt = 1'b0;
          end
        end
      end
      default: begin
        nxt     = cur;
        dir_nxt = dir;
      end
    endcase
  end

endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [SELW-1:0]   src_sel,
  input  logic [1:0]        div_sel,
  input  logic [1:0]        mode,
  input  logic [1:0]        len_sel,
  input  logic [CNT_W-1:0]  period,
  input  logic              clr,
  input  logic              ld,
  input  logic [CNT_W-1:0]  ld_val,
  output logic [CNT_W-1:0]  cnt,
  output logic              dir_down,
  output logic              evt_top,
  output logic              evt_zero
);

  localparam int CW = CNT_W;

  logic          run, adv;
  logic [CW-1:0] maxv, top, cur, nxt;
  logic          dir_nxt;
  mode_e         eff_mode;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          et_q, et_d, ez_q, ez_d;

  assign run = (mode != MODE_STOP);

  mm_tick_src #(.NSRC(NSRC), .SELW(SELW), .DIVW(3)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .src_sel  (src_sel),
    .div_sel  (div_sel),
    .run      (run),
    .clr      (clr),
    .adv      (adv)
  );

  mm_limit #(.CW(CW)) u_lim (
    .len_sel  (len_sel),
    .mode     (mode),
    .period   (period),
    .maxv     (maxv),
    .top      (top),
    .eff_mode (eff_mode)
  );

  assign cur = cnt_q & maxv;

  mm_step #(.CW(CW)) u_step (
    .cur      (cur),
    .dir      (dir_q),
    .eff_mode (eff_mode),
    .top      (top),
    .nxt      (nxt),
    .dir_nxt  (dir_nxt)
  );

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    et_d  = 1'b0;
    ez_d  = 1'b0;
    if (clr) begin
      cnt_d = '0;
      dir_d = 1'b0;
    end else if (ld) begin
      cnt_d = ld_val & maxv;
    end else if (adv) begin
      cnt_d = nxt;
      dir_d = dir_nxt;
      et_d  = (nxt == top) && (nxt != cur);
      ez_d  = (nxt == '0)  && (nxt != cur);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      et_q  <= 1'b0;
      ez_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      et_q  <= et_d;
      ez_q  <= ez_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = dir_q;
  assign evt_top  = et_q;
  assign evt_zero = ez_q;

endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic [1:0]  len_sel,
  input logic        clr,
  input logic        ld,
  input logic [15:0] cnt,
  input logic        dir_down,
  input logic        evt_top,
  input logic        evt_zero
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == 16'd0 && !dir_down && !evt_top && !evt_zero)); // R1

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !clr && !ld) |=> $stable(cnt)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode) == 2'd1 && $past(len_sel) == 2'd3 && !$past(clr) && !$past(ld)
     && cnt != $past(cnt)) |-> (cnt == 16'd0 || cnt == $past(cnt) + 16'd1)); // R3

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (!evt_top && !evt_zero)); // R10

  AST_ZERO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_zero |-> (cnt == 16'd0)); // R11

endmodule

bind mm_timer mm_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .len_sel  (len_sel),
  .clr      (clr),
  .ld       (ld),
  .cnt      (cnt),
  .dir_down (dir_down),
  .evt_top  (evt_top),
  .evt_zero (evt_zero)
);

// File: tb/sim_mm_timer.sv
module sim_mm_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  src_tick;
  logic [1:0]  src_sel, div_sel, mode, len_sel;
  logic [15:0] period, ld_val;
  logic        clr, ld;
  logic [15:0] cnt;
  logic        dir_down, evt_top, evt_zero;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  mm_timer u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
    .div_sel(div_sel), .mode(mode), .len_sel(len_sel), .period(period),
    .clr(clr), .ld(ld), .ld_val(ld_val), .cnt(cnt), .dir_down(dir_down),
    .evt_top(evt_top), .evt_zero(evt_zero)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive the given tick mask for n cycles; returns at the negedge after the last step
  task automatic pulse(input logic [3:0] m, input int n);
    src_tick = m;
    repeat (n) @(negedge clk);
    src_tick = 4'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] v);
    ld_val = v; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [1:0] ln,
                       input logic [1:0] dv, input logic [15:0] per);
    mode = md; len_sel = ln; div_sel = dv; period = per; src_sel = 2'd0;
    do_clear();
  endtask

  task automatic t_reset();
    check("R1 reset cnt", cnt, 0);
    check("R1 reset dir", dir_down, 0);
    check("R1 reset strobes", {evt_top, evt_zero}, 0);
  endtask

  task automatic t_continuous();
    setup(2'd2, 2'd0, 2'd0, 16'd0);
    pulse(4'b0001, 254);
    check("R4 cont count", cnt, 254);
    pulse(4'b0001, 1);
    check("R4 R6 cont full scale 8b", cnt, 255);
    check("R4 evt_top at full scale", evt_top, 1);
    pulse(4'b0001, 1);
    check("R4 cont wrap", cnt, 0);
    check("R4 evt_zero at wrap", evt_zero, 1);
  endtask

  task automatic t_up();
    setup(2'd1, 2'd3, 2'd0, 16'd5);
    pulse(4'b0001, 4);
    check("R3 up count", cnt, 4);
    check("R11 no strobe mid count", {evt_top, evt_zero}, 0);
    pulse(4'b0001, 1);
    check("R3 up at period", cnt, 5);
    check("R3 evt_top", evt_top, 1);
    idle();
    check("R11 strobe single cycle", evt_top, 0);
    pulse(4'b0001, 1);
    check("R3 up return", cnt, 0);
    check("R3 evt_zero", evt_zero, 1);
  endtask

  task automatic t_updown();
    setup(2'd3, 2'd3, 2'd0, 16'd3);
    pulse(4'b0001, 2);
    check("R5 rising", cnt, 2);
    check("R5 dir rising", dir_down, 0);
    pulse(4'b0001, 1);
    check("R5 at period", cnt, 3);
    check("R5 dir set at period", dir_down, 1);
    check("R5 evt_top", evt_top, 1);
    pulse(4'b0001, 1);
    check("R5 falling", cnt, 2);
    pulse(4'b0001, 2);
    check("R5 at zero", cnt, 0);
    check("R5 dir clear at zero", dir_down, 0);
    check("R5 evt_zero", evt_zero, 1);
    pulse(4'b0001, 1);
    check("R5 rises again", cnt, 1);
  endtask

  task automatic t_oversize();
    setup(2'd1, 2'd0, 2'd0, 16'd300);
    pulse(4'b0001, 256);
    check("R7 up oversize wraps at 255", cnt, 0);
    setup(2'd3, 2'd0, 2'd0, 16'd300);
    pulse(4'b0001, 255);
    check("R7 updown oversize top", cnt, 255);
    check("R7 updown oversize evt_top", evt_top, 1);
    check("R7 updown oversize dir", dir_down, 0);
    pulse(4'b0001, 1);
    check("R7 updown oversize wrap", cnt, 0);
  endtask

  task automatic t_divider();
    setup(2'd2, 2'd3, 2'd2, 16'd0);
    pulse(4'b0001, 7);
    check("R8 div4 after 7", cnt, 1);
    pulse(4'b0001, 1);
    check("R8 div4 after 8", cnt, 2);
    setup(2'd2, 2'd3, 2'd3, 16'd0);
    pulse(4'b0001, 16);
    check("R8 div8 after 16", cnt, 2);
    setup(2'd2, 2'd3, 2'd1, 16'd0);
    pulse(4'b0001, 6);
    check("R8 div2 after 6", cnt, 3);
    setup(2'd2, 2'd3, 2'd2, 16'd0);
    pulse(4'b0001, 3);
    do_clear();
    pulse(4'b0001, 3);
    check("R1 clear empties prescaler", cnt, 0);
    pulse(4'b0001, 1);
    check("R1 prescaler restarts", cnt, 1);
  endtask

  task automatic t_source();
    setup(2'd2, 2'd3, 2'd0, 16'd0);
    src_sel = 2'd1;
    pulse(4'b1101, 5);
    check("R9 other sources ignored", cnt, 0);
    src_sel = 2'd2;
    pulse(4'b0100, 5);
    check("R9 selected source counts", cnt, 5);
  endtask

  task automatic t_stop();
    setup(2'd2, 2'd3, 2'd0, 16'd0);
    pulse(4'b0001, 3);
    mode = 2'd0;
    pulse(4'b1111, 10);
    check("R2 stop holds", cnt, 3);
    mode = 2'd2;
    pulse(4'b0001, 1);
    check("R2 resume", cnt, 4);
  endtask

  task automatic t_load();
    setup(2'd1, 2'd3, 2'd0, 16'd5);
    do_load(16'd5);
    check("R10 load value", cnt, 5);
    check("R10 R11 load no strobe", {evt_top, evt_zero}, 0);
    pulse(4'b0001, 1);
    check("R3 step after load", cnt, 0);
    check("R11 evt_zero after load", evt_zero, 1);
    len_sel = 2'd0;
    do_load(16'h1234);
    check("R10 load masked", cnt, 16'h34);
    ld_val = 16'd77; ld = 1'b1; clr = 1'b1; src_tick = 4'b0001;
    @(negedge clk);
    ld = 1'b0; clr = 1'b0; src_tick = 4'b0;
    check("R10 clr over ld", cnt, 0);
    ld_val = 16'd9; ld = 1'b1; src_tick = 4'b0001;
    @(negedge clk);
    ld = 1'b0; src_tick = 4'b0;
    check("R10 tick dropped on load", cnt, 9);
  endtask

  task automatic t_length();
    setup(2'd2, 2'd3, 2'd0, 16'd0);
    do_load(16'h01FF);
    len_sel = 2'd0;
    idle();
    check("R12 count unchanged before tick", cnt, 16'h01FF);
    pulse(4'b0001, 1);
    check("R12 masked step wraps", cnt, 0);
    check("R12 evt_zero on masked wrap", evt_zero, 1);
    len_sel = 2'd1;
    do_load(16'd1022);
    pulse(4'b0001, 1);
    check("R6 10b full scale", cnt, 1023);
    check("R6 10b evt_top", evt_top, 1);
    pulse(4'b0001, 1);
    check("R6 10b wrap", cnt, 0);
    len_sel = 2'd2;
    do_load(16'd4095);
    pulse(4'b0001, 1);
    check("R6 12b wrap", cnt, 0);
    len_sel = 2'd3;
    do_load(16'hFFFF);
    pulse(4'b0001, 1);
    check("R6 16b wrap", cnt, 0);
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_tick = 4'b0; src_sel = 2'd0; div_sel = 2'd0;
    mode = 2'd0; len_sel = 2'd3; period = 16'd0; clr = 1'b0; ld = 1'b0;
    ld_val = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_continuous();
    t_up();
    t_updown();
    t_oversize();
    t_divider();
    t_source();
    t_stop();
    t_load();
    t_length();
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule